// File: doc/BRIEF.md
# Projector Power Sequencing Controller

This block is the top-level power controller of a display subsystem. After a chip reset it passes through two internal steps into OFF. When the projector-on input is high and no fault is present, it enables three logic rails one after another, releases the active-low array reset and rests in STANDBY. A display request then raises the three micromirror bias rails in a fixed order: offset, then bias, then reset. The block reaches DISPLAY ON after a one-cycle ready step. Power-down runs in the reverse order. The block asks for parking, drops the bias and reset rails together, drops the offset rail and runs a discharge step. It then returns to STANDBY, or to OFF when a fault was the reason for the shutdown.

The block reports its position as a fixed 5-bit state code. It also reports a 3-bit code that records why it last fell back to OFF, and a one-cycle flag that marks every state change. Every rail stage waits for its power-good handshake, with a cycle limit set by a parameter. Fault inputs are ranked by a fixed priority. A fault seen while the mirror rails are live always goes through parking and discharge. Regulators, watchdogs and thermal sensing are outside the block and appear only as input handshakes.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is held, the state code is 0x00, the cause code is 000, every enable output is low and every flag is low. After reset is released, the state code steps 0x00 → 0x01 → 0x02 (OFF) on successive cycles.
- R2: In OFF (0x02), when proj_on is high and no fault input is active, the next state is 0x03, followed by 0x04.
- R3: State 0x04 holds until pg_1v1 is high. State 0x05 holds until pg_1v8 is high. State 0x06 holds until pg_3v3 is high. State 0x07 lasts one cycle and then enters STANDBY (0x08).
- R4: STANDBY advances to 0x09 when disp_req is high. State 0x09 holds until pg_ofs is high, 0x0A until pg_bias is high and 0x0B until pg_vrst is high. State 0x0C lasts one cycle. State 0x0D holds while disp_req stays high.
- R5: In 0x0D, disp_req low leads to 0x0E. State 0x0E holds until park_done is high. States 0x0F and 0x10 last one cycle each. State 0x11 holds until dschg_done is high and then goes to STANDBY when no fault was seen on the way down.
- R6: Each output is high only over a fixed span of state codes. en_1v1 is high for 0x04–0x11, en_1v8 for 0x05–0x11, en_3v3 for 0x06–0x11 and array_rst_n for 0x07–0x11. en_ofs is high for 0x09–0x0F, en_bias and en_vrst for 0x0A–0x0E and 0x0B–0x0E, park_go for 0x0E only and dschg_go for 0x11 only.
- R7: The fault inputs have a fixed priority: ot_err, then wd1_err, then wd2_err, then sw_cycle, then proj_on low. The cause codes written are 100, 010, 011, 101 and 001 respectively. Only the winning input's code is latched.
- R8: A fault in states 0x03–0x08 moves the block to OFF on the next cycle. A fault in states 0x09–0x0D moves it to 0x0E on the next cycle, and the shutdown then ends in OFF.
- R9: A fault first seen in states 0x0E–0x11 leaves the shutdown order unchanged, but the block ends in OFF. Only the first fault of a shutdown sets the cause code.
- R10: A rail stage whose power-good stays low for TMO_CYC cycles sets pg_timeout. A logic-rail stage then goes to OFF, and a mirror-rail stage goes to 0x0E and sets mirror_fault. The cause code is left unchanged. Both flags clear in state 0x03.
- R11: Loss of power-good on an enabled mirror rail in 0x0A–0x0D sets mirror_fault and moves the block to 0x0E, and the shutdown then ends in OFF.
- R12: state_chg is high for exactly the one cycle that follows each change of the state code.
- R13: ot_warn_flag follows ot_warn one cycle later and has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| proj_on | input | 1 | Projector-on request |
| disp_req | input | 1 | Request to raise the mirror rails and display |
| pg_1v1 | input | 1 | Power-good of 1.1 V rail |
| pg_1v8 | input | 1 | Power-good of 1.8 V rail |
| pg_3v3 | input | 1 | Power-good of 3.3 V rail |
| pg_ofs | input | 1 | Power-good of mirror offset rail |
| pg_bias | input | 1 | Power-good of mirror bias rail |
| pg_vrst | input | 1 | Power-good of mirror reset rail |
| park_done | input | 1 | Parking sequence finished |
| dschg_done | input | 1 | Discharge finished |
| wd1_err | input | 1 | Watchdog 1 error |
| wd2_err | input | 1 | Watchdog 2 error |
| ot_err | input | 1 | Die over-temperature error |
| ot_warn | input | 1 | Die over-temperature warning |
| sw_cycle | input | 1 | Software power-cycle command |
| en_1v1 | output | 1 | 1.1 V rail enable |
| en_1v8 | output | 1 | 1.8 V rail enable |
| en_3v3 | output | 1 | 3.3 V rail enable |
| array_rst_n | output | 1 | Active-low array reset, high when released |
| en_ofs | output | 1 | Mirror offset rail enable |
| en_bias | output | 1 | Mirror bias rail enable |
| en_vrst | output | 1 | Mirror reset rail enable |
| park_go | output | 1 | Parking sequence request |
| dschg_go | output | 1 | Discharge request |
| state_code | output | 5 | Current state code |
| last_cause | output | 3 | Reason for the last fall back to OFF |
| state_chg | output | 1 | One-cycle pulse after a state change |
| pg_timeout | output | 1 | A rail stage timed out |
| mirror_fault | output | 1 | Mirror rail power-good fault or timeout |
| ot_warn_flag | output | 1 | Registered over-temperature warning |

## Verification
One slow bring-up holds each power-good low for several cycles before raising it, which shows that every stage waits on its own handshake and that the enables follow the state spans. Every one of the 31 combinations of the five fault inputs is applied in STANDBY, which separates the priority ranking from the cause encoding. Faults are injected in DISPLAY ON, during parking and during the one-cycle down steps, which tells the forced park path apart from a late fault that only redirects the final state. Held-low power-good on a logic stage and on a mirror stage, together with a dropped mirror rail, checks the exact timeout cycle and the two shutdown destinations.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [4:0] {
    ST_SHUTDOWN = 5'h00,
    ST_INIT_A   = 5'h01,
    ST_OFF      = 5'h02,
    ST_INIT_B   = 5'h03,
    ST_UP_1V1   = 5'h04,
    ST_UP_1V8   = 5'h05,
    ST_UP_3V3   = 5'h06,
    ST_RST_REL  = 5'h07,
    ST_STANDBY  = 5'h08,
    ST_MIR_OFS  = 5'h09,
    ST_MIR_BIAS = 5'h0A,
    ST_MIR_RST  = 5'h0B,
    ST_DISP_RDY = 5'h0C,
    ST_DISP_ON  = 5'h0D,
    ST_PARK     = 5'h0E,
    ST_BR_OFF   = 5'h0F,
    ST_OFS_OFF  = 5'h10,
    ST_DSCHG    = 5'h11
  } pstate_e;

  typedef enum logic [2:0] {
    CZ_POWER_ON = 3'd0,
    CZ_PON_LOW  = 3'd1,
    CZ_WD1      = 3'd2,
    CZ_WD2      = 3'd3,
    CZ_OVERTEMP = 3'd4,
    CZ_SW_CYCLE = 3'd5
  } cause_e;

  // fault request vector, index = priority (0 wins)
  localparam int unsigned N_FAULT = 5;
  // control output vector width
  localparam int unsigned N_CTL = 9;

endpackage

// File: rtl/pwr_seq_fault_arb.sv
module pwr_seq_fault_arb
  import pwr_seq_pkg::*;
(
  input  logic [N_FAULT-1:0] req,
  output logic               any,
  output cause_e             cause
);

  function automatic cause_e code_of(input int idx);
    case (idx)
      0:       code_of = CZ_OVERTEMP;
      1:       code_of = CZ_WD1;
      2:       code_of = CZ_WD2;
      3:       code_of = CZ_SW_CYCLE;
      4:       code_of = CZ_PON_LOW;
      default: code_of = CZ_POWER_ON;
    endcase
  endfunction

  always_comb begin
    any   = |req;
    cause = CZ_POWER_ON;
    for (int i = N_FAULT - 1; i >= 0; i--) begin
      if (req[i]) cause = code_of(i);
    end
  end

  // over-temperature can never be outranked
  always_comb begin
    if (req[0] == 1'b1) begin
      assert_ot_first_R7: assert (cause == CZ_OVERTEMP);
    end
  end

endmodule

// File: rtl/pwr_seq_wait_tmr.sv
module pwr_seq_wait_tmr #(
  parameter int unsigned TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expired
);

  localparam int unsigned CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          cnt_en;

  assign expired = run && (cnt_q == LAST);
  assign cnt_en  = clr || (run && !expired);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= clr ? '0 : cnt_q + 1'b1;
    end
  end

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_expire_only_waiting_R10: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> run);

endmodule

// File: rtl/pwr_seq_out_dec.sv
module pwr_seq_out_dec
  import pwr_seq_pkg::*;
(
  input  logic [4:0]       st,
  output logic [N_CTL-1:0] ctl
);

  // bit order: 1v1, 1v8, 3v3, rst_rel, ofs, bias, vrst, park, dschg
  localparam logic [4:0] LO [N_CTL] = '{5'h04, 5'h05, 5'h06, 5'h07, 5'h09,
                                        5'h0A, 5'h0B, 5'h0E, 5'h11};
  localparam logic [4:0] HI [N_CTL] = '{5'h11, 5'h11, 5'h11, 5'h11, 5'h0F,
                                        5'h0E, 5'h0E, 5'h0E, 5'h11};

  for (genvar g = 0; g < N_CTL; g++) begin : g_span
    assign ctl[g] = (st >= LO[g]) && (st <= HI[g]);
  end

  always_comb begin
    if (ctl[6] == 1'b1) begin
      assert_mirror_nest_R6: assert (ctl[5] && ctl[4]);
    end
    if (ctl[8] == 1'b1) begin
      assert_dschg_quiet_R6: assert (!ctl[4] && !ctl[5] && !ctl[6]);
    end
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned TMO_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       proj_on,
  input  logic       disp_req,
  input  logic       pg_1v1,
  input  logic       pg_1v8,
  input  logic       pg_3v3,
  input  logic       pg_ofs,
  input  logic       pg_bias,
  input  logic       pg_vrst,
  input  logic       park_done,
  input  logic       dschg_done,
  input  logic       wd1_err,
  input  logic       wd2_err,
  input  logic       ot_err,
  input  logic       ot_warn,
  input  logic       sw_cycle,
  output logic       en_1v1,
  output logic       en_1v8,
  output logic       en_3v3,
  output logic       array_rst_n,
  output logic       en_ofs,
  output logic       en_bias,
  output logic       en_vrst,
  output logic       park_go,
  output logic       dschg_go,
  output logic [4:0] state_code,
  output logic [2:0] last_cause,
  output logic       state_chg,
  output logic       pg_timeout,
  output logic       mirror_fault,
  output logic       ot_warn_flag
);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  pstate_e state_q, state_d;
  cause_e  cause_q, flt_cause;
  logic    cause_en;
  logic    fshut_q, fshut_d;
  logic    tmo_q, tmo_d;
  logic    mf_q, mf_d;
  logic    chg_q, warn_q;
  logic    flt_any;
  logic    in_up, in_mir, in_down;
  logic    wait_st, pg_ok, mir_lost, tmo_hit;
  logic [N_FAULT-1:0] flt_req;
  logic [N_CTL-1:0]   ctl;

  assign flt_req = {!proj_on, sw_cycle, wd2_err, wd1_err, ot_err};

  pwr_seq_fault_arb u_arb (
    .req   (flt_req),
    .any   (flt_any),
    .cause (flt_cause)
  );

  pwr_seq_wait_tmr #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (wait_st),
    .clr     (state_d != state_q),
    .expired (tmo_hit)
  );

  pwr_seq_out_dec u_dec (
    .st  (state_q),
    .ctl (ctl)
  );

  assign in_up   = (state_q >= ST_INIT_B)  && (state_q <= ST_STANDBY);
  assign in_mir  = (state_q >= ST_MIR_OFS) && (state_q <= ST_DISP_ON);
  assign in_down = (state_q >= ST_PARK)    && (state_q <= ST_DSCHG);

  // handshake awaited by the current rail stage
  always_comb begin
    wait_st = 1'b1;
    pg_ok   = 1'b1;
    case (state_q)
      ST_UP_1V1:   pg_ok = pg_1v1;
      ST_UP_1V8:   pg_ok = pg_1v8;
      ST_UP_3V3:   pg_ok = pg_3v3;
      ST_MIR_OFS:  pg_ok = pg_ofs;
      ST_MIR_BIAS: pg_ok = pg_bias;
      ST_MIR_RST:  pg_ok = pg_vrst;
      default:     wait_st = 1'b0;
    endcase
  end

  // power-good lost on a mirror rail that is already up
  always_comb begin
    case (state_q)
      ST_MIR_BIAS:             mir_lost = !pg_ofs;
      ST_MIR_RST:              mir_lost = !(pg_ofs && pg_bias);
      ST_DISP_RDY, ST_DISP_ON: mir_lost = !(pg_ofs && pg_bias && pg_vrst);
      default:                 mir_lost = 1'b0;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    fshut_d  = fshut_q;
    tmo_d    = tmo_q;
    mf_d     = mf_q;
    cause_en = 1'b0;

    if (flt_any && in_up) cause_en = 1'b1;
    if (flt_any && (in_mir || in_down)) begin
      cause_en = !fshut_q;
      fshut_d  = 1'b1;
    end

    case (state_q)
      ST_SHUTDOWN: state_d = ST_INIT_A;
      ST_INIT_A:   state_d = ST_OFF;
      ST_OFF: begin
        fshut_d = 1'b0;
        if (!flt_any) state_d = ST_INIT_B;
      end
      ST_INIT_B: begin
        tmo_d   = 1'b0;
        mf_d    = 1'b0;
        state_d = ST_UP_1V1;
      end
      ST_UP_1V1, ST_UP_1V8, ST_UP_3V3: begin
        if (pg_ok) begin
          state_d = pstate_e'(state_q + 5'd1);
        end else if (tmo_hit) begin
          tmo_d   = 1'b1;
          state_d = ST_OFF;
        end
      end
      ST_RST_REL: state_d = ST_STANDBY;
      ST_STANDBY: if (disp_req) state_d = ST_MIR_OFS;
      ST_MIR_OFS, ST_MIR_BIAS, ST_MIR_RST: begin
        if (mir_lost) begin
          mf_d    = 1'b1;
          fshut_d = 1'b1;
          state_d = ST_PARK;
        end else if (pg_ok) begin
          state_d = pstate_e'(state_q + 5'd1);
        end else if (tmo_hit) begin
          tmo_d   = 1'b1;
          mf_d    = 1'b1;
          fshut_d = 1'b1;
          state_d = ST_PARK;
        end
      end
      ST_DISP_RDY: begin
        if (mir_lost) begin
          mf_d    = 1'b1;
          fshut_d = 1'b1;
          state_d = ST_PARK;
        end else begin
          state_d = ST_DISP_ON;
        end
      end
      ST_DISP_ON: begin
        if (mir_lost) begin
          mf_d    = 1'b1;
          fshut_d = 1'b1;
          state_d = ST_PARK;
        end else if (!disp_req) begin
          state_d = ST_PARK;
        end
      end
      ST_PARK:    if (park_done) state_d = ST_BR_OFF;
      ST_BR_OFF:  state_d = ST_OFS_OFF;
      ST_OFS_OFF: state_d = ST_DSCHG;
      ST_DSCHG:   if (dschg_done) state_d = fshut_d ? ST_OFF : ST_STANDBY;
      default:    state_d = ST_SHUTDOWN;
    endcase

    // external faults override the normal order
    if (flt_any && in_up)  state_d = ST_OFF;
    if (flt_any && in_mir) state_d = ST_PARK;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_SHUTDOWN;
      fshut_q <= 1'b0;
      tmo_q   <= 1'b0;
      mf_q    <= 1'b0;
      chg_q   <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fshut_q <= fshut_d;
      tmo_q   <= tmo_d;
      mf_q    <= mf_d;
      chg_q   <= (state_d != state_q);
      warn_q  <= ot_warn;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)      cause_q <= CZ_POWER_ON;
    else if (cause_en) cause_q <= flt_cause;
  end

  assign {dschg_go, park_go, en_vrst, en_bias, en_ofs,
          array_rst_n, en_3v3, en_1v8, en_1v1} = ctl;
  assign state_code   = state_q;
  assign last_cause   = cause_q;
  assign state_chg    = chg_q;
  assign pg_timeout   = tmo_q;
  assign mirror_fault = mf_q;
  assign ot_warn_flag = warn_q;

  assert_chg_pulse_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    chg_q |-> (state_q != $past(state_q)));

  assert_down_chain_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_BR_OFF) |=> (state_q == ST_OFS_OFF));

  assert_ot_parks_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ot_err && in_mir) |=> (state_q == ST_PARK));

  assert_up_fault_off_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (flt_any && in_up) |=> (state_q == ST_OFF));

  assert_late_fault_off_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_DSCHG && dschg_done && fshut_q) |=> (state_q == ST_OFF));

  assert_cause_legal_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    cause_q <= CZ_SW_CYCLE);

endmodule

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;

  localparam int TMO = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic proj_on, disp_req, pg_1v1, pg_1v8, pg_3v3, pg_ofs, pg_bias, pg_vrst;
  logic park_done, dschg_done, wd1_err, wd2_err, ot_err, ot_warn, sw_cycle;
  logic en_1v1, en_1v8, en_3v3, array_rst_n, en_ofs, en_bias, en_vrst;
  logic park_go, dschg_go, state_chg, pg_timeout, mirror_fault, ot_warn_flag;
  logic [4:0] state_code;
  logic [2:0] last_cause;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl #(.TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .proj_on(proj_on), .disp_req(disp_req),
    .pg_1v1(pg_1v1), .pg_1v8(pg_1v8), .pg_3v3(pg_3v3), .pg_ofs(pg_ofs),
    .pg_bias(pg_bias), .pg_vrst(pg_vrst), .park_done(park_done),
    .dschg_done(dschg_done), .wd1_err(wd1_err), .wd2_err(wd2_err),
    .ot_err(ot_err), .ot_warn(ot_warn), .sw_cycle(sw_cycle),
    .en_1v1(en_1v1), .en_1v8(en_1v8), .en_3v3(en_3v3),
    .array_rst_n(array_rst_n), .en_ofs(en_ofs), .en_bias(en_bias),
    .en_vrst(en_vrst), .park_go(park_go), .dschg_go(dschg_go),
    .state_code(state_code), .last_cause(last_cause), .state_chg(state_chg),
    .pg_timeout(pg_timeout), .mirror_fault(mirror_fault),
    .ot_warn_flag(ot_warn_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_ctl(input int s);
    exp_ctl[0] = (s >= 4)  && (s <= 17);
    exp_ctl[1] = (s >= 5)  && (s <= 17);
    exp_ctl[2] = (s >= 6)  && (s <= 17);
    exp_ctl[3] = (s >= 7)  && (s <= 17);
    exp_ctl[4] = (s >= 9)  && (s <= 15);
    exp_ctl[5] = (s >= 10) && (s <= 14);
    exp_ctl[6] = (s >= 11) && (s <= 14);
    exp_ctl[7] = (s == 14);
    exp_ctl[8] = (s == 17);
  endfunction

  function automatic logic [8:0] dut_ctl();
    return {dschg_go, park_go, en_vrst, en_bias, en_ofs,
            array_rst_n, en_3v3, en_1v8, en_1v1};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // state code plus the enable spans of R6
  task automatic chk_st(input int exp, input string req);
    check(state_code == 5'(exp), req, "state", int'(state_code), exp);
    check(dut_ctl() == exp_ctl(exp), "R6", "enables", int'(dut_ctl()),
          int'(exp_ctl(exp)));
  endtask

  task automatic wait_state(input int s, input string req);
    for (int i = 0; i < 80; i++) begin
      if (state_code == 5'(s)) return;
      tick(1);
    end
    check(1'b0, req, "reach state", int'(state_code), s);
  endtask

  task automatic clear_faults();
    proj_on = 1'b1; wd1_err = 1'b0; wd2_err = 1'b0; ot_err = 1'b0;
    sw_cycle = 1'b0;
  endtask

  function automatic int prio_code(input int c);
    if (c[0]) return 4;
    if (c[1]) return 2;
    if (c[2]) return 3;
    if (c[3]) return 5;
    return 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; proj_on = 1'b0; disp_req = 1'b0;
    pg_1v1 = 1'b0; pg_1v8 = 1'b0; pg_3v3 = 1'b0;
    pg_ofs = 1'b0; pg_bias = 1'b0; pg_vrst = 1'b0;
    park_done = 1'b0; dschg_done = 1'b0; wd1_err = 1'b0; wd2_err = 1'b0;
    ot_err = 1'b0; ot_warn = 1'b0; sw_cycle = 1'b0;
    tick(3);
    // R1 reset state
    chk_st(0, "R1");
    check(last_cause == 3'd0, "R1", "cause", int'(last_cause), 0);
    check({state_chg, pg_timeout, mirror_fault, ot_warn_flag} == 4'b0, "R1",
          "flags", int'({state_chg, pg_timeout, mirror_fault, ot_warn_flag}), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) if (state_code == 5'd0) tick(1);
    chk_st(1, "R1");
    tick(1);
    chk_st(2, "R1");
    check(state_chg == 1'b1, "R12", "chg pulse", int'(state_chg), 1);
    tick(1);
    check(state_chg == 1'b0, "R12", "chg idle", int'(state_chg), 0);
    chk_st(2, "R1");

    // slow bring-up, every handshake late
    proj_on = 1'b1;
    tick(1); chk_st(3, "R2");
    tick(1); chk_st(4, "R2");
    tick(3); chk_st(4, "R3");
    pg_1v1 = 1'b1; tick(1); chk_st(5, "R3");
    tick(2); chk_st(5, "R3");
    pg_1v8 = 1'b1; tick(1); chk_st(6, "R3");
    tick(1); chk_st(6, "R3");
    pg_3v3 = 1'b1; tick(1); chk_st(7, "R3");
    tick(1); chk_st(8, "R3");
    tick(2); chk_st(8, "R4");
    disp_req = 1'b1; tick(1); chk_st(9, "R4");
    tick(2); chk_st(9, "R4");
    pg_ofs = 1'b1; tick(1); chk_st(10, "R4");
    tick(1); chk_st(10, "R4");
    pg_bias = 1'b1; tick(1); chk_st(11, "R4");
    tick(1); chk_st(11, "R4");
    pg_vrst = 1'b1; tick(1); chk_st(12, "R4");
    tick(1); chk_st(13, "R4");
    tick(3); chk_st(13, "R4");
    disp_req = 1'b0; tick(1); chk_st(14, "R5");
    tick(2); chk_st(14, "R5");
    park_done = 1'b1; tick(1); chk_st(15, "R5");
    park_done = 1'b0;
    tick(1); chk_st(16, "R5");
    tick(1); chk_st(17, "R5");
    tick(2); chk_st(17, "R5");
    dschg_done = 1'b1; tick(1); chk_st(8, "R5");
    dschg_done = 1'b0;
    check(last_cause == 3'd0, "R5", "cause", int'(last_cause), 0);

    // R13 warning only flags
    ot_warn = 1'b1; tick(1);
    check(ot_warn_flag == 1'b1, "R13", "warn flag", int'(ot_warn_flag), 1);
    check(state_code == 5'd8, "R13", "state", int'(state_code), 8);
    ot_warn = 1'b0; tick(1);
    check(ot_warn_flag == 1'b0, "R13", "warn clear", int'(ot_warn_flag), 0);

    // R7 R8 all fault combinations in STANDBY
    for (int c = 1; c < 32; c++) begin
      ot_err = c[0]; wd1_err = c[1]; wd2_err = c[2]; sw_cycle = c[3];
      proj_on = !c[4];
      tick(1);
      check(state_code == 5'd2, "R8", "standby fault", int'(state_code), 2);
      check(int'(last_cause) == prio_code(c), "R7", "cause", int'(last_cause),
            prio_code(c));
      clear_faults();
      wait_state(8, "R2");
    end

    // R8 fault in DISPLAY ON, R9 later fault keeps path and cause
    disp_req = 1'b1; wait_state(13, "R4");
    wd2_err = 1'b1; tick(1); chk_st(14, "R8");
    check(last_cause == 3'd3, "R8", "cause", int'(last_cause), 3);
    wd2_err = 1'b0; disp_req = 1'b0;
    park_done = 1'b1; tick(1); chk_st(15, "R9");
    park_done = 1'b0; ot_err = 1'b1; tick(1); chk_st(16, "R9");
    ot_err = 1'b0; tick(1); chk_st(17, "R9");
    dschg_done = 1'b1; tick(1); chk_st(2, "R9");
    dschg_done = 1'b0;
    check(last_cause == 3'd3, "R9", "first cause kept", int'(last_cause), 3);

    // R9 fault first seen during parking after a normal request
    wait_state(8, "R2");
    disp_req = 1'b1; wait_state(13, "R4");
    disp_req = 1'b0; tick(1); chk_st(14, "R5");
    sw_cycle = 1'b1; tick(1); chk_st(14, "R9");
    sw_cycle = 1'b0; park_done = 1'b1; tick(1); chk_st(15, "R9");
    park_done = 1'b0; tick(2); chk_st(17, "R9");
    dschg_done = 1'b1; tick(1); chk_st(2, "R9");
    dschg_done = 1'b0;
    check(last_cause == 3'd5, "R9", "cause", int'(last_cause), 5);

    // R10 logic rail timeout
    pg_1v8 = 1'b0;
    wait_state(5, "R3");
    tick(TMO - 1); chk_st(5, "R10");
    check(pg_timeout == 1'b0, "R10", "no early flag", int'(pg_timeout), 0);
    tick(1); chk_st(2, "R10");
    check(pg_timeout == 1'b1, "R10", "flag", int'(pg_timeout), 1);
    check(last_cause == 3'd5, "R10", "cause unchanged", int'(last_cause), 5);
    pg_1v8 = 1'b1;
    wait_state(8, "R2");
    check(pg_timeout == 1'b0, "R10", "flag cleared", int'(pg_timeout), 0);

    // R10 mirror rail timeout
    pg_bias = 1'b0; disp_req = 1'b1;
    wait_state(10, "R4");
    tick(TMO - 1); chk_st(10, "R10");
    tick(1); chk_st(14, "R10");
    check(pg_timeout == 1'b1, "R10", "flag", int'(pg_timeout), 1);
    check(mirror_fault == 1'b1, "R10", "mirror flag", int'(mirror_fault), 1);
    pg_bias = 1'b1; disp_req = 1'b0; park_done = 1'b1; dschg_done = 1'b1;
    tick(4); chk_st(2, "R10");
    park_done = 1'b0; dschg_done = 1'b0;

    // R11 mirror rail lost in DISPLAY ON
    wait_state(8, "R2");
    check(mirror_fault == 1'b0, "R10", "mirror cleared", int'(mirror_fault), 0);
    disp_req = 1'b1; wait_state(13, "R4");
    pg_ofs = 1'b0; tick(1); chk_st(14, "R11");
    check(mirror_fault == 1'b1, "R11", "mirror flag", int'(mirror_fault), 1);
    pg_ofs = 1'b1; park_done = 1'b1; dschg_done = 1'b1;
    tick(4); chk_st(2, "R11");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule